// File: doc/BRIEF.md
# Horizontal microprogrammed accumulator controller

This block is a small processor control unit in which a wide control word, read each cycle from an internal control store, drives the datapath directly. Every single-bit field of the word is one control line. The lines are: operand address onto the memory address bus, accumulator onto ALU input 1, memory read data onto ALU input 2, accumulator latch, memory write strobe, accumulator onto the write-data bus, instruction-register load, program-counter increment and program-counter load. A 3-bit field codes the ALU operation. A 2-bit field gives extra settle cycles. A 2-bit sequencing field and an 8-bit literal micro-address complete the 24-bit word.

User instructions are compact 8-bit words held in an external synchronous memory. That memory returns read data one clock after the address and writes on a clock edge when the strobe is high. A fetch microroutine at micro-address 0 loads the instruction register and advances the program counter. A dispatch table then sends each opcode to its own short microroutine. Every microroutine ends by branching back to fetch.

Top module: `uctl_acc`

## Requirements
- R1: While reset is held and just after it is released, acc_out is 0, zero_out is 1, mem_we is 0, and mem_addr is 0 because fetch starts from program address 0.
- R2: Instructions are fetched from consecutive program addresses starting at 0 and execute in that order. An instruction word is {opcode[7:5], operand address[4:0]}.
- R3: Opcode 3 (store) writes acc_out to the operand address. It is the only opcode that asserts mem_we. When mem_we is low, memory is only read.
- R4: The microword's wait count holds the word and its control lines for that many extra cycles. The accumulator changes only on the last cycle. For a load at program address 0, acc_out first shows the new value after the 6th rising edge following reset release.
- R5: The ALU codes are 000 pass input 1, 001 add and 010 AND. Opcode 0 loads memory into the accumulator (add with input 1 zero). Opcode 1 adds memory to the accumulator, modulo 256. Opcode 2 ANDs memory into the accumulator.
- R6: Opcode 4 loads the program counter with the operand address unconditionally.
- R7: Opcode 5 loads the program counter with the operand address only when the zero flag is set. Otherwise execution continues with the next instruction.
- R8: The zero flag is registered each time the accumulator is loaded and equals 1 exactly when the new accumulator value is 0.
- R9: Opcodes 6 and 7 write nothing: the accumulator, the flag and memory are left unchanged, and execution continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 5 | Memory address: program counter or operand address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| acc_out | output | 8 | Accumulator |
| zero_out | output | 1 | Zero flag |

## Verification
The bench times the first load after reset to the exact edge. A design that latched before the settle cycles were over would show the value early, and one that held too long would show it late. Conditional jumps run with the flag both set and clear: a sequencer with an inverted or stale condition takes the wrong path and ends with the wrong accumulator value. Undefined opcodes carry an operand address that points at a preset memory cell, so any stray write or accumulator update shows up in that cell or in acc_out. Carry wrap and AND results of zero test the flag and the dropped ninth bit.

// File: rtl/uctl_acc.sv
module uctl_acc #(
  parameter int DW  = 8,
  parameter int AW  = 5,
  parameter int UAW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_out,
  output logic          zero_out
);
  localparam int OPW = DW - AW;
  localparam int MW  = 16 + UAW;

  localparam logic [1:0] SQ_INC = 2'd0, SQ_JMP = 2'd1, SQ_BRZ = 2'd2, SQ_DSP = 2'd3;
  localparam logic [2:0] ALU_PASS = 3'b000, ALU_ADD = 3'b001, ALU_AND = 3'b010;
  localparam logic [8:0] C_SA = 9'h100, C_SB = 9'h080, C_AO = 9'h040, C_AL = 9'h020,
                         C_WE = 9'h010, C_WD = 9'h008, C_IR = 9'h004, C_PI = 9'h002,
                         C_PL = 9'h001;
  localparam logic [UAW-1:0] U_DISP = UAW'(2), U_NOP = UAW'(14);

  function automatic logic [MW-1:0] mw(input logic [1:0] sq, input logic [UAW-1:0] nx,
                                       input logic [1:0] wt, input logic [2:0] op,
                                       input logic [8:0] ctl);
    return {sq, nx, wt, op, ctl};
  endfunction

  function automatic logic [MW-1:0] ucode(input logic [UAW-1:0] a);
    case (int'(a))
      0:  return mw(SQ_INC, '0, 2'd0, ALU_PASS, 9'h000);
      1:  return mw(SQ_INC, '0, 2'd0, ALU_PASS, C_IR | C_PI);
      2:  return mw(SQ_DSP, '0, 2'd0, ALU_PASS, 9'h000);
      3:  return mw(SQ_INC, '0, 2'd0, ALU_PASS, C_AO);
      4:  return mw(SQ_JMP, '0, 2'd1, ALU_ADD,  C_AO | C_SB | C_AL);
      5:  return mw(SQ_INC, '0, 2'd0, ALU_PASS, C_AO);
      6:  return mw(SQ_JMP, '0, 2'd2, ALU_ADD,  C_AO | C_SA | C_SB | C_AL);
      7:  return mw(SQ_INC, '0, 2'd0, ALU_PASS, C_AO);
      8:  return mw(SQ_JMP, '0, 2'd1, ALU_AND,  C_AO | C_SA | C_SB | C_AL);
      9:  return mw(SQ_JMP, '0, 2'd0, ALU_PASS, C_AO | C_WE | C_WD);
      10: return mw(SQ_JMP, '0, 2'd0, ALU_PASS, C_PL);
      11: return mw(SQ_BRZ, UAW'(13), 2'd0, ALU_PASS, 9'h000);
      12: return mw(SQ_JMP, '0, 2'd0, ALU_PASS, 9'h000);
      13: return mw(SQ_JMP, '0, 2'd0, ALU_PASS, C_PL);
      default: return mw(SQ_JMP, '0, 2'd0, ALU_PASS, 9'h000);
    endcase
  endfunction

  function automatic logic [UAW-1:0] dispatch(input logic [OPW-1:0] op);
    case (int'(op))
      0: return UAW'(3);
      1: return UAW'(5);
      2: return UAW'(7);
      3: return UAW'(9);
      4: return UAW'(10);
      5: return UAW'(11);
      default: return U_NOP;
    endcase
  endfunction

  logic [UAW-1:0] upc, nupc;
  logic [1:0]     cnt;
  logic [AW-1:0]  pc;
  logic [DW-1:0]  ir, acc, in1, in2, alu;
  logic           zero;
  logic [MW-1:0]  uw;

  assign uw = ucode(upc);
  wire [1:0]     sq  = uw[MW-1 -: 2];
  wire [UAW-1:0] nx  = uw[MW-3 -: UAW];
  wire [1:0]     wt  = uw[13:12];
  wire [2:0]     aop = uw[11:9];
  wire fin   = (cnt == wt);
  wire acc_w = uw[5] & fin;
  wire [OPW-1:0] opc = ir[DW-1:AW];

  assign in1       = uw[8] ? acc : '0;
  assign in2       = uw[7] ? mem_rdata : '0;
  assign mem_addr  = uw[6] ? ir[AW-1:0] : pc;
  assign mem_we    = uw[4] & fin;
  assign mem_wdata = uw[3] ? acc : '0;
  assign acc_out   = acc;
  assign zero_out  = zero;

  always_comb begin
    case (aop)
      ALU_PASS: alu = in1;
      ALU_ADD:  alu = in1 + in2;
      ALU_AND:  alu = in1 & in2;
      default:  alu = '0;
    endcase
    case (sq)
      SQ_INC:  nupc = upc + 1'b1;
      SQ_JMP:  nupc = nx;
      SQ_BRZ:  nupc = zero ? nx : upc + 1'b1;
      default: nupc = dispatch(opc);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upc <= '0; cnt <= '0; pc <= '0; ir <= '0; acc <= '0; zero <= 1'b1;
    end else if (!fin) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      upc <= nupc;
      if (uw[2]) ir <= mem_rdata;
      if (uw[0]) pc <= ir[AW-1:0];
      else if (uw[1]) pc <= pc + 1'b1;
      if (acc_w) begin
        acc  <= alu;
        zero <= (alu == '0);
      end
    end
  end

  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n) !fin |=> $stable(acc));
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> (zero == (acc == '0)));
  a_r3_store_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == acc));
  a_r9_undef_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == U_DISP && int'(opc) > 5) |=> (upc == U_NOP));
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && uw[1] && !uw[0]) |=> (pc == $past(pc) + 1'b1));
endmodule

// File: tb/uctl_acc_test.sv
`timescale 1ns/1ps
module uctl_acc_test;
  logic clk = 0, rst_n = 0;
  logic [4:0] mem_addr;
  logic mem_we;
  logic [7:0] mem_wdata, mem_rdata, acc_out;
  logic zero_out;
  logic [7:0] mem [32];
  int nchk = 0, nfail = 0;

  uctl_acc uut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
                .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_out(acc_out),
                .zero_out(zero_out));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  localparam logic [31:0] VEC [5] = '{
    {8'h03, 8'h04, 8'h07, 8'h00},
    {8'hFF, 8'h01, 8'h00, 8'h01},
    {8'h0F, 8'hF0, 8'hFF, 8'h00},
    {8'hAA, 8'hAA, 8'h54, 8'hAA},
    {8'h00, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
  endtask

  task automatic start();
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic hold_reset();
    @(negedge clk) rst_n = 0;
    clr();
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    hold_reset();
    run(2);
    chk("R1 acc", acc_out, 0);
    chk("R1 zero", zero_out, 1);
    chk("R1 we", mem_we, 0);
    chk("R1 addr", mem_addr, 0);

    for (int v = 0; v < 5; v++) begin
      hold_reset();
      mem[0] = 8'h14; mem[1] = 8'h35; mem[2] = 8'h76; mem[3] = 8'h14;
      mem[4] = 8'h55; mem[5] = 8'h77; mem[6] = 8'h86;
      mem[20] = VEC[v][31:24]; mem[21] = VEC[v][23:16];
      start();
      run(100);
      chk("R5 add stored (R3)", mem[22], VEC[v][15:8]);
      chk("R5 and stored (R3)", mem[23], VEC[v][7:0]);
      chk("R5 acc", acc_out, VEC[v][7:0]);
      chk("R8 zero", zero_out, (VEC[v][7:0] == 0));
      chk("R6 jump loop R2", mem_we, 0);
    end

    hold_reset();
    mem[0] = 8'h14; mem[1] = 8'h86; mem[20] = 8'h5A;
    start();
    run(5);
    chk("R4 acc before last wait cycle", acc_out, 0);
    run(1);
    chk("R4 acc at 6th edge", acc_out, 8'h5A);
    chk("R8 zero after nonzero load", zero_out, 0);

    for (int t = 0; t < 2; t++) begin
      hold_reset();
      mem[0] = 8'h18; mem[1] = 8'hA4; mem[2] = 8'h19; mem[3] = 8'h83;
      mem[4] = 8'h1A; mem[5] = 8'h85;
      mem[24] = (t == 0) ? 8'h00 : 8'h01; mem[25] = 8'h11; mem[26] = 8'h22;
      start();
      run(80);
      chk((t == 0) ? "R7 taken" : "R7 not taken", acc_out, (t == 0) ? 8'h22 : 8'h11);
    end

    hold_reset();
    mem[0] = 8'h83; mem[1] = 8'h19; mem[2] = 8'h82; mem[3] = 8'h1A; mem[4] = 8'h84;
    mem[25] = 8'h11; mem[26] = 8'h22;
    start();
    run(80);
    chk("R6 jump skips", acc_out, 8'h22);

    hold_reset();
    mem[0] = 8'h14; mem[1] = 8'hD6; mem[2] = 8'hF6; mem[3] = 8'h77; mem[4] = 8'h84;
    mem[20] = 8'h33; mem[22] = 8'h99;
    start();
    run(27);
    chk("R9 acc kept", acc_out, 8'h33);
    chk("R9 flag kept", zero_out, 0);
    chk("R9 mem untouched", mem[22], 8'h99);
    run(60);
    chk("R9 continues R2", mem[23], 8'h33);
    chk("R9 mem still untouched", mem[22], 8'h99);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule